// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Connection Controller

This block decides when the two-wire bus (data and clock) of a plug-in card is joined to a live backplane bus. Its inputs are the raw logic levels of both backplane lines and both card lines, a supply-good flag and an active-low select. Each input passes through a synchronizer inside the block. Its outputs are a link enable, a precharge enable, a ready indication and four drive-low enables, one for each pad.

After the supply becomes good, the block watches the backplane for the end of a transaction. That end is either a STOP, or both backplane lines staying high for a set number of clock cycles. At that point it also checks that both card lines are high. Only when all of these hold does it join the two buses. While joined, each line behaves as one wired-AND net: a low pulled on either side is repeated onto the other side, and the net returns high only when every device on both sides has released it. Raising the select breaks the link in the same cycle. Any later rejoin has to qualify again from the start.

Top module: `hs_link_ctrl`

## Requirements
- R1: While the synchronized supply-good flag is low, the link stays off, precharge_en is 1, ready is 0, and bus activity (including a STOP) leaves no trace once the supply becomes good.
- R2: In the qualifying state, a backplane STOP (data rising while clock is high) joins the buses, provided both card lines are high.
- R3: Bus idle means both backplane lines have been high for IDLE_CYCLES consecutive clock cycles. Any low on either backplane line restarts the count from zero, so continuous clock toggling never qualifies.
- R4: The buses are joined only while both card data and card clock read high. If either is low when a STOP or idle arrives, the block keeps waiting.
- R5: While linked, a low driven by a device on one side of a line makes the block assert the drive-low enable of the other side (enable = 1 means pull low). The block releases that enable once the originating side reads high. Data and clock are handled independently.
- R6: sel_n = 1 drops link_en, ready and all four drive-low enables in the same cycle, without waiting for a clock edge.
- R7: After sel_n returns to 0, the block rejoins only after a fresh STOP or a full idle interval that starts after the return.
- R8: ready = 1 exactly when the block is in the joined state and sel_n = 0.
- R9: precharge_en = 1 in every state except the joined state.
- R10: A drive-low enable is never 1 while link_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good flag, asynchronous |
| sel_n | input | 1 | Active-low select; 1 isolates the buses |
| bp_sda_i | input | 1 | Backplane data level |
| bp_scl_i | input | 1 | Backplane clock level |
| cd_sda_i | input | 1 | Card data level |
| cd_scl_i | input | 1 | Card clock level |
| bp_sda_pd | output | 1 | Pull backplane data low |
| bp_scl_pd | output | 1 | Pull backplane clock low |
| cd_sda_pd | output | 1 | Pull card data low |
| cd_scl_pd | output | 1 | Pull card clock low |
| link_en | output | 1 | Buses joined |
| precharge_en | output | 1 | Precharge active |
| ready | output | 1 | Ready indication (1 = released high) |

## Verification
The bench toggles the backplane clock for many idle intervals without ever producing a STOP. A timer that failed to restart on a low would join the buses in the middle of a transaction. It also holds a card line low across a STOP and across an idle interval; a block that skipped the card check would join anyway. After the select is raised and lowered again, the bench watches for an early rejoin, which is what a design that remembered an old qualification would do. Finally, it overlaps pulls from both sides of one line, so that a join that latched its own drive, or that linked data to clock, would leave a line stuck low or would pull the wrong line.

// File: rtl/hs_link_pkg.sv
// Shared state encodings for the hot-swap link controller.
// Assumes: included before every module of the block.
package hs_link_pkg;
    typedef enum logic [1:0] {
        ST_LOCKOUT   = 2'd0,
        ST_WAIT_QUAL = 2'd1,
        ST_CONNECTED = 2'd2,
        ST_ISOLATED  = 2'd3
    } link_state_t;

    typedef enum logic [1:0] {
        LN_IDLE     = 2'd0,
        LN_DRIVE_CD = 2'd1,
        LN_DRIVE_BP = 2'd2,
        LN_SETTLE   = 2'd3
    } line_state_t;
endpackage

// File: rtl/hs_sync.sv
// Multi-flop synchronizer for a bundle of asynchronous levels.
// Assumes: STAGES >= 2; each bit is an independent slow level.
module hs_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the sampled levels one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hs_bus_monitor.sv
// Backplane watcher: flags a STOP and a completed bus-idle interval.
// Assumes: sda/scl are already synchronized; arm low clears the timer.
module hs_bus_monitor #(
    parameter int IDLE_CYCLES = 9500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic sda,
    input  logic scl,
    output logic stop_seen,
    output logic idle_done
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYCLES);

    logic          sda_prev;
    logic [CW-1:0] idle_cnt;

    // Remember the previous data level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda;
    end

    // Count consecutive high cycles on both lines, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  idle_cnt <= '0;
        else if (!arm || !sda || !scl) idle_cnt <= '0;
        else if (idle_cnt != IDLE_MAX) idle_cnt <= idle_cnt + 1'b1;
    end

    assign stop_seen = arm && scl && sda && !sda_prev;
    assign idle_done = arm && (idle_cnt == IDLE_MAX);
endmodule

// File: rtl/hs_line_join.sv
// Wired-AND join of one line across the two sides. It tracks which side
// started the low so that it never latches on its own repeated drive.
// Assumes: inputs are synchronized with SYNC_STAGES flops of delay.
module hs_line_join
    import hs_link_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_en,
    input  logic bp_i,
    input  logic cd_i,
    output logic bp_pd,
    output logic cd_pd
);
    localparam int HW = $clog2(SYNC_STAGES + 1) + 1;
    localparam logic [HW-1:0] SETTLE_LAST = HW'(SYNC_STAGES);

    line_state_t       ln_q;
    logic [HW-1:0]     settle_cnt;

    // Track the owner of the low and blank stale samples after a release.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en) begin
            ln_q       <= LN_IDLE;
            settle_cnt <= '0;
        end else begin
            unique case (ln_q)
                LN_IDLE: begin
                    if (!bp_i)      ln_q <= LN_DRIVE_CD;
                    else if (!cd_i) ln_q <= LN_DRIVE_BP;
                end
                LN_DRIVE_CD: if (bp_i) begin
                    ln_q       <= LN_SETTLE;
                    settle_cnt <= '0;
                end
                LN_DRIVE_BP: if (cd_i) begin
                    ln_q       <= LN_SETTLE;
                    settle_cnt <= '0;
                end
                LN_SETTLE: begin
                    if (settle_cnt == SETTLE_LAST) ln_q <= LN_IDLE;
                    else settle_cnt <= settle_cnt + 1'b1;
                end
                default: ln_q <= LN_IDLE;
            endcase
        end
    end

    assign cd_pd = link_en && (ln_q == LN_DRIVE_CD);
    assign bp_pd = link_en && (ln_q == LN_DRIVE_BP);
endmodule

// File: rtl/hs_link_ctrl.sv
// Top of the hot-swap link controller: synchronizers, the connection
// state machine, the backplane monitor and one join unit per line.
// Assumes: all inputs are asynchronous; the select acts on the outputs
// combinationally so that isolation needs no clock edge.
module hs_link_ctrl
    import hs_link_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYCLES = 9500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic sel_n,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic cd_sda_i,
    input  logic cd_scl_i,
    output logic bp_sda_pd,
    output logic bp_scl_pd,
    output logic cd_sda_pd,
    output logic cd_scl_pd,
    output logic link_en,
    output logic precharge_en,
    output logic ready
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] bp_s, cd_s, bp_pd_v, cd_pd_v;
    logic              sup_s, sel_s;
    logic              stop_seen, idle_done, card_high;
    link_state_t       state_q;

    hs_sync #(.WIDTH(2 * NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cd_scl_i, cd_sda_i, bp_scl_i, bp_sda_i}),
        .q({cd_s, bp_s})
    );

    hs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({supply_ok, sel_n}),
        .q({sup_s, sel_s})
    );

    hs_bus_monitor #(.IDLE_CYCLES(IDLE_CYCLES)) u_mon (
        .clk(clk), .rst_n(rst_n),
        .arm(state_q == ST_WAIT_QUAL),
        .sda(bp_s[0]), .scl(bp_s[1]),
        .stop_seen(stop_seen), .idle_done(idle_done)
    );

    assign card_high = &cd_s;

    // Connection state machine: lockout, qualification, joined, isolated.
    always_ff @(posedge clk) begin
        if (!rst_n || !sup_s) begin
            state_q <= ST_LOCKOUT;
        end else begin
            unique case (state_q)
                ST_LOCKOUT:   state_q <= sel_s ? ST_ISOLATED : ST_WAIT_QUAL;
                ST_WAIT_QUAL: begin
                    if (sel_s) state_q <= ST_ISOLATED;
                    else if ((stop_seen || idle_done) && card_high)
                        state_q <= ST_CONNECTED;
                end
                ST_CONNECTED: if (sel_s)  state_q <= ST_ISOLATED;
                ST_ISOLATED:  if (!sel_s) state_q <= ST_WAIT_QUAL;
                default:      state_q <= ST_LOCKOUT;
            endcase
        end
    end

    assign link_en      = (state_q == ST_CONNECTED) && !sel_n;
    assign ready        = link_en;
    assign precharge_en = (state_q != ST_CONNECTED);

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        hs_line_join #(.SYNC_STAGES(SYNC_STAGES)) u_join (
            .clk(clk), .rst_n(rst_n), .link_en(link_en),
            .bp_i(bp_s[i]), .cd_i(cd_s[i]),
            .bp_pd(bp_pd_v[i]), .cd_pd(cd_pd_v[i])
        );
    end

    assign bp_sda_pd = bp_pd_v[0];
    assign bp_scl_pd = bp_pd_v[1];
    assign cd_sda_pd = cd_pd_v[0];
    assign cd_scl_pd = cd_pd_v[1];
endmodule

// File: rtl/hs_link_ctrl_chk.sv
// Property checker for hs_link_ctrl, attached with bind.
// Assumes: connected to the internal state and synchronized card levels.
module hs_link_ctrl_chk
    import hs_link_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input link_state_t state,
    input logic        sel_n,
    input logic        card_high,
    input logic        stop_seen,
    input logic        idle_done,
    input logic        link_en,
    input logic        ready,
    input logic        precharge_en,
    input logic        bp_sda_pd,
    input logic        bp_scl_pd,
    input logic        cd_sda_pd,
    input logic        cd_scl_pd
);
    p_lockout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOCKOUT |-> !link_en && precharge_en && !ready);

    p_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONNECTED && $past(state) != ST_CONNECTED)
        |-> $past(state) == ST_WAIT_QUAL && $past(stop_seen || idle_done));

    p_card_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONNECTED && $past(state) != ST_CONNECTED) |-> $past(card_high));

    p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bp_sda_pd && cd_sda_pd) && !(bp_scl_pd && cd_scl_pd));

    p_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !link_en && !ready);

    p_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state) == ST_ISOLATED |-> state != ST_CONNECTED);

    p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> state == ST_CONNECTED && !sel_n);

    p_precharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |-> !precharge_en);
endmodule

bind hs_link_ctrl hs_link_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .sel_n(sel_n),
    .card_high(card_high), .stop_seen(stop_seen), .idle_done(idle_done),
    .link_en(link_en), .ready(ready), .precharge_en(precharge_en),
    .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd),
    .cd_sda_pd(cd_sda_pd), .cd_scl_pd(cd_scl_pd)
);

// File: tb/sim_hs_link_ctrl.sv
// Directed bench for hs_link_ctrl. Pads are modelled as wired-AND nets of
// bench devices and the block's drive-low enables.
module sim_hs_link_ctrl;
    localparam int IDLE = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic sel_n = 1'b0;
    logic dv_bp_sda = 1'b0, dv_bp_scl = 1'b0, dv_cd_sda = 1'b0, dv_cd_scl = 1'b0;
    logic bp_sda, bp_scl, cd_sda, cd_scl;
    logic bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd;
    logic link_en, precharge_en, ready;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign bp_sda = !(dv_bp_sda || bp_sda_pd);
    assign bp_scl = !(dv_bp_scl || bp_scl_pd);
    assign cd_sda = !(dv_cd_sda || cd_sda_pd);
    assign cd_scl = !(dv_cd_scl || cd_scl_pd);

    hs_link_ctrl #(.SYNC_STAGES(2), .IDLE_CYCLES(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sel_n(sel_n),
        .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .cd_sda_i(cd_sda), .cd_scl_i(cd_scl),
        .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd),
        .cd_sda_pd(cd_sda_pd), .cd_scl_pd(cd_scl_pd),
        .link_en(link_en), .precharge_en(precharge_en), .ready(ready)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(2);
        chk(link_en, 1'b0, "R1 link off in reset/lockout");
        chk(precharge_en, 1'b1, "R9 precharge on at reset");
        chk(ready, 1'b0, "R8 ready low at reset");
    endtask

    task automatic t_lockout;
        dv_bp_sda = 1'b1; cyc(5);
        dv_bp_sda = 1'b0; cyc(20);
        chk(link_en, 1'b0, "R1 STOP ignored during lockout");
        chk(precharge_en, 1'b1, "R1 precharge held in lockout");
    endtask

    task automatic t_mid_transaction;
        logic seen = 1'b0;
        dv_bp_sda = 1'b1;
        cyc(2);
        supply_ok = 1'b1;
        for (int i = 0; i < 3 * IDLE / 10; i++) begin
            dv_bp_scl = ~dv_bp_scl;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (link_en) seen = 1'b1;
            end
        end
        chk(seen, 1'b0, "R3 no join while backplane clock toggles");
        chk(ready, 1'b0, "R8 ready low before join");
    endtask

    task automatic t_stop;
        dv_bp_scl = 1'b0; cyc(5);
        dv_bp_sda = 1'b0; cyc(10);
        chk(link_en, 1'b1, "R2 joined after STOP");
        chk(ready, 1'b1, "R8 ready high when joined");
        chk(precharge_en, 1'b0, "R9 precharge off when joined");
    endtask

    task automatic t_join;
        dv_bp_sda = 1'b1; cyc(6);
        chk(cd_sda, 1'b0, "R5 backplane data low repeated to card");
        chk(cd_scl, 1'b1, "R5 card clock unaffected by data");
        dv_bp_sda = 1'b0; cyc(10);
        chk(cd_sda && bp_sda, 1'b1, "R5 data released on both sides");
        dv_cd_scl = 1'b1; cyc(6);
        chk(bp_scl_pd, 1'b1, "R5 card clock low repeated to backplane");
        dv_cd_scl = 1'b0; cyc(10);
        chk(bp_scl && cd_scl, 1'b1, "R5 clock released on both sides");
        dv_cd_sda = 1'b1; cyc(6);
        dv_bp_sda = 1'b1; cyc(6);
        dv_cd_sda = 1'b0; cyc(12);
        chk(cd_sda, 1'b0, "R5 card data held low by backplane device");
        dv_bp_sda = 1'b0; cyc(12);
        chk(cd_sda && bp_sda, 1'b1, "R5 data high once every device releases");
    endtask

    task automatic t_select;
        dv_bp_sda = 1'b1; cyc(6);
        sel_n = 1'b1; #1;
        chk(link_en, 1'b0, "R6 link drops with select");
        chk(ready, 1'b0, "R6 ready drops with select");
        chk(cd_sda_pd, 1'b0, "R10 no card drive while isolated");
        cyc(4);
        chk(cd_sda, 1'b1, "R10 card data not pulled while isolated");
        dv_bp_sda = 1'b0; cyc(10);
    endtask

    task automatic t_reconnect;
        sel_n = 1'b0;
        cyc(IDLE - 20);
        chk(link_en, 1'b0, "R7 no early rejoin after select returns");
        cyc(40);
        chk(link_en, 1'b1, "R3 joined after full idle interval");
    endtask

    task automatic t_card_low;
        sel_n = 1'b1; cyc(5);
        dv_cd_sda = 1'b1;
        sel_n = 1'b0; cyc(5);
        dv_bp_sda = 1'b1; cyc(5);
        dv_bp_sda = 1'b0; cyc(IDLE + 20);
        chk(link_en, 1'b0, "R4 no join while card data low");
        dv_cd_sda = 1'b0; cyc(10);
        chk(link_en, 1'b1, "R4 join once card lines high");
    endtask

    task automatic t_supply_drop;
        supply_ok = 1'b0; cyc(5);
        chk(link_en, 1'b0, "R1 link off after supply loss");
        chk(precharge_en, 1'b1, "R1 precharge back on after supply loss");
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        t_reset();
        t_lockout();
        t_mid_transaction();
        t_stop();
        t_join();
        t_select();
        t_reconnect();
        t_card_low();
        t_supply_drop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule